// File: doc/BRIEF.md
# Scaled-Plane Sample Coordinate Generator

This block walks a destination rectangle of programmable width and height, one output pixel per accepted transfer, in row-major order. For each destination pixel it reports where in the source image the sample lies: an integer source column and row, two 8-bit interpolation weights, the destination placement of the pixel, and whether the downstream filter should blend four neighbours or take a single nearest sample. Pixel fetch and the blend arithmetic live elsewhere; this block only produces the addresses and weights.

Source positions are tracked in 16.16 fixed point. The walk starts from a sub-pixel source origin given in 4.4 fixed point and moves by a programmable 16.16 step per output pixel horizontally and per output row vertically. The source extent is given as a count of 16-pixel column groups and 8-line row groups, and every reported coordinate is kept inside that extent. All settings are captured when a frame is started, so they may change freely while a frame is running.

Top module: `scl_coord_gen`

## Requirements
- R1: A `start` pulse while idle captures every setting; the first coordinate is presented with `out_valid` high in the following cycle, at destination (`dst_x0`, `dst_y0`).
- R2: Each accepted transfer (`out_valid` and `out_ready` both high) that is not the last of its row adds `step_x` (16.16) to the horizontal source position; after the last pixel of a row the horizontal position returns to the origin.
- R3: After the last pixel of each row the vertical source position grows by `step_y` (16.16); it is constant within a row.
- R4: The origin `org_x`/`org_y` is 4.4 fixed point (bits 7:4 integer, 3:0 fraction) and becomes the 16.16 position `org << 12`.
- R5: With bilinear mode on, the source coordinate is the integer part of the position and the weight is position bits 15:8.
- R6: With bilinear mode off, the coordinate is the position rounded half up to an integer and both weights are zero; `bilin_out` shows the captured mode.
- R7: The source column is clamped to `16*src_wblk - 1` and the source row to `8*src_hblk - 1`; a group count of zero clamps to 0.
- R8: While `out_valid` is high and `out_ready` low, every output holds its value.
- R9: `done` is high for exactly one cycle, the cycle after the last pixel of the rectangle is accepted, and `out_valid` is low in that cycle.
- R10: A start with a destination width or height of zero produces no valid output and raises `done` in the following cycle.
- R11: A `start` pulse while a frame is in progress is ignored, and the settings of the running frame stay in force.
- R12: The destination outputs are `dst_x0 + column` and `dst_y0 + row`, modulo 2^12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| dst_w | input | 12 | Destination width in pixels |
| dst_h | input | 12 | Destination height in rows |
| dst_x0 | input | 12 | Destination placement column |
| dst_y0 | input | 12 | Destination placement row |
| step_x | input | 32 | Horizontal step, 16.16 |
| step_y | input | 32 | Vertical step, 16.16 |
| org_x | input | 8 | Horizontal source origin, 4.4 |
| org_y | input | 8 | Vertical source origin, 4.4 |
| src_wblk | input | 8 | Source width in 16-pixel groups |
| src_hblk | input | 8 | Source height in 8-line groups |
| bilin_en | input | 1 | 1 = bilinear weights, 0 = nearest sample |
| out_ready | input | 1 | Consumer accepts the current coordinate |
| out_valid | output | 1 | Coordinate present |
| src_x | output | 12 | Source column |
| src_y | output | 12 | Source row |
| wgt_x | output | 8 | Horizontal weight |
| wgt_y | output | 8 | Vertical weight |
| dst_x | output | 12 | Destination column |
| dst_y | output | 12 | Destination row |
| bilin_out | output | 1 | Filter mode of the current frame |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A corrupted accumulator appears on `src_x` or `wgt_x` at the very next presented pixel, and because the horizontal position is rebuilt from the origin at every row end, a horizontal error is confined to its row while a vertical error persists for the rest of the frame. A miscounting sequencer shows up as a wrong `dst_x`/`dst_y` immediately, or as `done` arriving early or late against the expected pixel count. Comparing every output against an independent model on every clock, with stalls inserted by random backpressure, exposes both kinds within a cycle of the fault.

// File: rtl/scl_pkg.sv
package scl_pkg;
    // Fraction bits of the running source position and of the origin input.
    localparam int FIX_FRAC = 16;
    localparam int ORG_FRAC = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_e;
endpackage

// File: rtl/scl_seq.sv
// Destination raster sequencer: column/row counters, frame phase, done pulse.
module scl_seq
    import scl_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dim_w,
    input  logic [DW-1:0] dim_h,
    input  logic          fire,
    output logic          accept,
    output logic          busy,
    output logic          last_col,
    output logic [DW-1:0] col,
    output logic [DW-1:0] row,
    output logic          done
);

    typedef struct packed {
        seq_e          ph;
        logic [DW-1:0] col;
        logic [DW-1:0] row;
        logic [DW-1:0] w;
        logic [DW-1:0] h;
        logic          done;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            SEQ_IDLE: begin
                if (start) begin
                    st_d.w   = dim_w;
                    st_d.h   = dim_h;
                    st_d.col = '0;
                    st_d.row = '0;
                    if (dim_w == '0 || dim_h == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.ph = SEQ_RUN;
                    end
                end
            end
            SEQ_RUN: begin
                if (fire) begin
                    if (st_q.col == st_q.w - 1'b1) begin
                        st_d.col = '0;
                        if (st_q.row == st_q.h - 1'b1) begin
                            st_d.ph   = SEQ_IDLE;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.row = st_q.row + 1'b1;
                        end
                    end else begin
                        st_d.col = st_q.col + 1'b1;
                    end
                end
            end
            default: st_d.ph = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: SEQ_IDLE, col: '0, row: '0, w: '0, h: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign accept   = (st_q.ph == SEQ_IDLE) && start;
    assign busy     = (st_q.ph == SEQ_RUN);
    assign last_col = (st_q.col == st_q.w - 1'b1);
    assign col      = st_q.col;
    assign row      = st_q.row;
    assign done     = st_q.done;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R9
    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (col < st_q.w) && (row < st_q.h));                          // R12
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !fire |=> $stable(col) && $stable(row));            // R11

endmodule

// File: rtl/scl_accum.sv
// One 16.16 source-position accumulator with a rewind-to-origin path.
module scl_accum
    import scl_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          rewind,
    input  logic          adv,
    input  logic [OW-1:0] org,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] acc
);

    localparam int SH = FIX_FRAC - ORG_FRAC;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [AW-1:0] base;
    } acc_t;

    acc_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = AW'(org) << SH;
            st_d.acc  = AW'(org) << SH;
        end else if (rewind) begin
            st_d.acc = st_q.base;
        end else if (adv) begin
            st_d.acc = st_q.acc + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !load && !rewind |=> acc == $past(acc) + $past(step));        // R2
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !load && !rewind |=> $stable(acc));                          // R8

endmodule

// File: rtl/scl_sample.sv
// Turns a 16.16 position into a clamped integer coordinate and a weight.
module scl_sample
    import scl_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 12,
    parameter int BW  = 8,
    parameter int WW  = 8,
    parameter int BSH = 4
) (
    input  logic [AW-1:0] acc,
    input  logic [BW-1:0] blocks,
    input  logic          bilin,
    output logic [CW-1:0] coord,
    output logic [WW-1:0] wgt
);

    localparam int IW = AW - FIX_FRAC;
    localparam logic [AW:0] HALF = (AW + 1)'(1) << (FIX_FRAC - 1);

    logic [CW:0]   span;
    logic [CW-1:0] lim;
    logic [AW:0]   rnd;
    logic [IW:0]   ip;

    always_comb begin
        span = ((CW + 1)'(blocks)) << BSH;
        lim  = (span == '0) ? '0 : CW'(span - 1'b1);
        rnd  = {1'b0, acc} + HALF;
        if (bilin) begin
            ip  = {1'b0, acc[AW-1:FIX_FRAC]};
            wgt = acc[FIX_FRAC-1 -: WW];
        end else begin
            ip  = rnd[AW:FIX_FRAC];
            wgt = '0;
        end
        if (ip > (IW + 1)'(lim)) begin
            coord = lim;
        end else begin
            coord = CW'(ip);
        end
    end

endmodule

// File: rtl/scl_coord_gen.sv
// Top: settings capture, destination placement, handshake, two axis pipes.
module scl_coord_gen
    import scl_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 12,
    parameter int BW = 8,
    parameter int AW = 32,
    parameter int OW = 8,
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dst_w,
    input  logic [DW-1:0] dst_h,
    input  logic [DW-1:0] dst_x0,
    input  logic [DW-1:0] dst_y0,
    input  logic [AW-1:0] step_x,
    input  logic [AW-1:0] step_y,
    input  logic [OW-1:0] org_x,
    input  logic [OW-1:0] org_y,
    input  logic [BW-1:0] src_wblk,
    input  logic [BW-1:0] src_hblk,
    input  logic          bilin_en,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [CW-1:0] src_x,
    output logic [CW-1:0] src_y,
    output logic [WW-1:0] wgt_x,
    output logic [WW-1:0] wgt_y,
    output logic [DW-1:0] dst_x,
    output logic [DW-1:0] dst_y,
    output logic          bilin_out,
    output logic          done
);

    localparam int XSH = 4;   // column group = 16 pixels
    localparam int YSH = 3;   // row group = 8 lines

    typedef struct packed {
        logic [DW-1:0] x0;
        logic [DW-1:0] y0;
        logic [AW-1:0] sx;
        logic [AW-1:0] sy;
        logic [BW-1:0] bx;
        logic [BW-1:0] by;
        logic          bil;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic          accept, busy, last_col, fire;
    logic [DW-1:0] col, row;
    logic [AW-1:0] acc_x, acc_y;

    always_comb begin
        cfg_d = cfg_q;
        if (accept) begin
            cfg_d.x0  = dst_x0;
            cfg_d.y0  = dst_y0;
            cfg_d.sx  = step_x;
            cfg_d.sy  = step_y;
            cfg_d.bx  = src_wblk;
            cfg_d.by  = src_hblk;
            cfg_d.bil = bilin_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fire = out_valid && out_ready;

    scl_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dim_w    (dst_w),
        .dim_h    (dst_h),
        .fire     (fire),
        .accept   (accept),
        .busy     (busy),
        .last_col (last_col),
        .col      (col),
        .row      (row),
        .done     (done)
    );

    scl_accum #(.AW(AW), .OW(OW)) u_acc_x (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .rewind (fire && last_col),
        .adv    (fire && !last_col),
        .org    (org_x),
        .step   (cfg_q.sx),
        .acc    (acc_x)
    );

    scl_accum #(.AW(AW), .OW(OW)) u_acc_y (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .rewind (1'b0),
        .adv    (fire && last_col),
        .org    (org_y),
        .step   (cfg_q.sy),
        .acc    (acc_y)
    );

    scl_sample #(.AW(AW), .CW(CW), .BW(BW), .WW(WW), .BSH(XSH)) u_smp_x (
        .acc    (acc_x),
        .blocks (cfg_q.bx),
        .bilin  (cfg_q.bil),
        .coord  (src_x),
        .wgt    (wgt_x)
    );

    scl_sample #(.AW(AW), .CW(CW), .BW(BW), .WW(WW), .BSH(YSH)) u_smp_y (
        .acc    (acc_y),
        .blocks (cfg_q.by),
        .bilin  (cfg_q.bil),
        .coord  (src_y),
        .wgt    (wgt_y)
    );

    assign out_valid = busy;
    assign bilin_out = cfg_q.bil;
    assign dst_x     = cfg_q.x0 + col;
    assign dst_y     = cfg_q.y0 + row;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(src_x) && $stable(src_y)
            && $stable(wgt_x) && $stable(wgt_y) && $stable(dst_x) && $stable(dst_y)); // R8
    AST_NEAREST_ZERO_WGT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !bilin_out |-> (wgt_x == '0) && (wgt_y == '0));          // R6
    AST_CLAMP_X: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((CW + 1)'(src_x) < (((CW + 1)'(cfg_q.bx)) << XSH))
            || (src_x == '0));                                               // R7
    AST_CLAMP_Y: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((CW + 1)'(src_y) < (((CW + 1)'(cfg_q.by)) << YSH))
            || (src_y == '0));                                               // R7
    AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);                                                // R9
    AST_FIRST_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dst_w != '0 && dst_h != '0 |=> out_valid && dst_x == $past(dst_x0)
            && dst_y == $past(dst_y0));                                      // R1

endmodule

// File: tb/scl_coord_gen_test.sv
module scl_coord_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] dst_w = 12'd0, dst_h = 12'd0, dst_x0 = 12'd0, dst_y0 = 12'd0;
    logic [31:0] step_x = 32'd0, step_y = 32'd0;
    logic [7:0]  org_x = 8'd0, org_y = 8'd0, src_wblk = 8'd1, src_hblk = 8'd1;
    logic        bilin_en = 1'b0;
    logic        out_ready = 1'b1;
    logic        out_valid, bilin_out, done;
    logic [11:0] src_x, src_y, dst_x, dst_y;
    logic [7:0]  wgt_x, wgt_y;

    always #10 clk = ~clk;   // 50 MHz

    scl_coord_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dst_w(dst_w), .dst_h(dst_h), .dst_x0(dst_x0), .dst_y0(dst_y0),
        .step_x(step_x), .step_y(step_y), .org_x(org_x), .org_y(org_y),
        .src_wblk(src_wblk), .src_hblk(src_hblk), .bilin_en(bilin_en),
        .out_ready(out_ready), .out_valid(out_valid), .src_x(src_x), .src_y(src_y),
        .wgt_x(wgt_x), .wgt_y(wgt_y), .dst_x(dst_x), .dst_y(dst_y),
        .bilin_out(bilin_out), .done(done)
    );

    int    checks = 0;
    int    errors = 0;
    int    rmode  = 0;
    string phase  = "R1";
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input string fld, input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", tag, phase, fld, act, exp, $time);
        end
    endtask

    // Inputs as seen at each rising edge.
    logic        s_start, s_ready, s_bil;
    logic [11:0] s_w, s_h, s_x0, s_y0;
    logic [31:0] s_sx, s_sy;
    logic [7:0]  s_ox, s_oy, s_bx, s_by;
    always @(posedge clk) begin
        s_start <= start;  s_ready <= out_ready;  s_bil <= bilin_en;
        s_w <= dst_w;  s_h <= dst_h;  s_x0 <= dst_x0;  s_y0 <= dst_y0;
        s_sx <= step_x;  s_sy <= step_y;  s_ox <= org_x;  s_oy <= org_y;
        s_bx <= src_wblk;  s_by <= src_hblk;
    end

    // Behavioural reference state.
    bit          m_busy = 1'b0, m_bil = 1'b0;
    int          m_col = 0, m_row = 0, m_w = 0, m_h = 0, m_x0 = 0, m_y0 = 0, m_bx = 0, m_by = 0;
    logic [31:0] m_ax = 32'd0, m_ay = 32'd0, m_base = 32'd0, m_sx = 32'd0, m_sy = 32'd0;

    function automatic longint exp_crd(input logic [31:0] a, input int blk, input int grp, input bit bil);
        longint p, lim;
        p = longint'({32'd0, a});
        if (bil) p = p / 65536;
        else     p = (p + 32768) / 65536;
        lim = (blk == 0) ? 0 : blk * grp - 1;
        return (p > lim) ? lim : p;
    endfunction

    function automatic longint exp_wgt(input logic [31:0] a, input bit bil);
        return bil ? longint'((a / 256) % 256) : 0;
    endfunction

    always @(negedge clk) begin
        bit exp_done;
        exp_done = 1'b0;
        if (rst_n) begin
            if (m_busy && s_ready) begin
                if (m_col == m_w - 1) begin
                    m_col = 0;
                    m_ax  = m_base;
                    m_ay  = m_ay + m_sy;
                    if (m_row == m_h - 1) begin
                        m_busy   = 1'b0;
                        exp_done = 1'b1;
                    end else begin
                        m_row++;
                    end
                end else begin
                    m_col++;
                    m_ax = m_ax + m_sx;
                end
            end else if (!m_busy && s_start) begin
                m_w = int'(s_w);  m_h = int'(s_h);  m_x0 = int'(s_x0);  m_y0 = int'(s_y0);
                m_sx = s_sx;  m_sy = s_sy;  m_bx = int'(s_bx);  m_by = int'(s_by);  m_bil = s_bil;
                m_base = 32'(s_ox) * 32'd4096;
                m_ax = m_base;
                m_ay = 32'(s_oy) * 32'd4096;
                m_col = 0;  m_row = 0;
                if (m_w == 0 || m_h == 0) exp_done = 1'b1;   // R10
                else m_busy = 1'b1;
            end
            chk("out_valid", "R1", longint'(out_valid), longint'(m_busy));
            chk("done", "R9", longint'(done), longint'(exp_done));
            if (m_busy && out_valid) begin
                chk("src_x", "R2", longint'(src_x), exp_crd(m_ax, m_bx, 16, m_bil));
                chk("src_y", "R3", longint'(src_y), exp_crd(m_ay, m_by, 8, m_bil));
                chk("wgt_x", "R5", longint'(wgt_x), exp_wgt(m_ax, m_bil));
                chk("wgt_y", "R5", longint'(wgt_y), exp_wgt(m_ay, m_bil));
                chk("dst_x", "R12", longint'(dst_x), longint'((m_x0 + m_col) % 4096));
                chk("dst_y", "R12", longint'(dst_y), longint'((m_y0 + m_row) % 4096));
                chk("bilin_out", "R6", longint'(bilin_out), longint'(m_bil));
            end
        end
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (rmode)
            0:       out_ready = 1'b1;
            1:       out_ready = lf[0];
            default: out_ready = lf[0] & lf[3];
        endcase
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic setup(input int w, input int h, input int x0, input int y0,
                         input logic [31:0] sx, input logic [31:0] sy,
                         input logic [7:0] ox, input logic [7:0] oy,
                         input logic [7:0] bx, input logic [7:0] by, input bit bil);
        dst_w = 12'(w);  dst_h = 12'(h);  dst_x0 = 12'(x0);  dst_y0 = 12'(y0);
        step_x = sx;  step_y = sy;  org_x = ox;  org_y = oy;
        src_wblk = bx;  src_hblk = by;  bilin_en = bil;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        chk("reset out_valid", "R1", longint'(out_valid), 0);
        chk("reset done", "R9", longint'(done), 0);

        // R4 R5: 2x upscale from a half-pixel origin, bilinear, no stalls.
        phase = "R4";  rmode = 0;
        setup(5, 3, 10, 20, 32'h0000_8000, 32'h0000_8000, 8'h08, 8'h18, 8'd1, 8'd1, 1'b1);
        pulse_start();  wait_done();

        // R6 R7: 2.5x downscale, nearest sample, edges clamp, random stalls.
        phase = "R7";  rmode = 1;
        setup(10, 4, 4090, 7, 32'h0002_8000, 32'h0003_0000, 8'h13, 8'h2C, 8'd1, 8'd1, 1'b0);
        pulse_start();  wait_done();

        // R10: empty rectangles.
        phase = "R10";  rmode = 0;
        setup(0, 5, 0, 0, 32'h0001_0000, 32'h0001_0000, 8'h00, 8'h00, 8'd2, 8'd2, 1'b1);
        pulse_start();  wait_done();
        setup(5, 0, 0, 0, 32'h0001_0000, 32'h0001_0000, 8'h00, 8'h00, 8'd2, 8'd2, 1'b0);
        pulse_start();  wait_done();

        // R11: second start during a frame, with different settings.
        phase = "R11";  rmode = 1;
        setup(6, 4, 3, 3, 32'h0000_C000, 32'h0001_4000, 8'h05, 8'h0B, 8'd2, 8'd1, 1'b1);
        pulse_start();
        repeat (4) @(negedge clk);
        setup(2, 2, 100, 200, 32'h0004_0000, 32'h0004_0000, 8'hFF, 8'hFF, 8'd0, 8'd0, 1'b0);
        pulse_start();
        wait_done();

        // R8: heavy backpressure; also zero group counts (clamp to 0, R7).
        phase = "R8";  rmode = 2;
        setup(7, 3, 1, 2, 32'h0001_2000, 32'h0000_9000, 8'h0F, 8'h01, 8'd3, 8'd0, 1'b1);
        pulse_start();  wait_done();
        setup(4, 4, 50, 60, 32'h0001_8000, 32'h0001_8000, 8'h07, 8'h09, 8'd0, 8'd4, 1'b0);
        pulse_start();  wait_done();

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule